// File: doc/BRIEF.md
# Pipelined Data-Port Memory Slave

This block answers a processor data port that issues address and control one cycle before the data. When the active-low request line is low at a rising edge, the block captures the address, access size, direction, lock and sequential hint. The following cycle is the data phase. In that cycle the block reads or writes a 256-word internal RAM. Byte and halfword writes use byte-lane enables. Sub-word reads come back zero-extended. Accesses that are not allowed raise an abort in the data phase.

A second bus master shares the RAM through a request/grant handshake. It may use the RAM only in a cycle the processor leaves free. A lock or a pending sequential access holds it off. The processor always wins a tie.

Control is a three-state machine:
- **S_IDLE**: no access this cycle.
- **S_CPU**: processor data phase.
- **S_ALT**: alternate-master data phase.

At each edge the next state is chosen as follows:
- **S_CPU** when the processor requests, from any state.
- **S_ALT** when the alternate master requests and the cycle is free. A cycle is free when the processor is not requesting, the lock line is low, and the block is not in an S_CPU phase whose access carried the sequential hint.
- **S_IDLE** in every other case.

Top module: `dp_mem_slave`

## Requirements
- R1: When `cpu_req_n` is low at a rising edge, the next cycle is a data phase.
  - Read data and abort are valid in that cycle.
  - A write takes its data from `cpu_wdata` in that cycle and commits at the edge that ends it.
  - A write followed back to back by a read of the same word returns the new data.
- R2: The size code selects the access width: 2'b00 byte, 2'b01 halfword, 2'b10 word. A byte read returns the lane chosen by address bits 1:0, zero-extended into bits 7:0. A halfword read returns the half chosen by address bit 1, zero-extended into bits 15:0. `cpu_rdata` is zero outside read data phases.
- R3: Byte lanes are numbered little-endian: lane k is bits 8k+7:8k.
  - A byte write updates only lane `addr[1:0]`.
  - A halfword write updates only lanes 2·addr[1] and 2·addr[1]+1.
  - A word write updates all four lanes.
  - Each updated lane takes its data from the same lane of `cpu_wdata`.
- R4: The following accesses raise `cpu_abort` in the data phase:
  - size code 2'b11 (reserved);
  - a halfword access with address bit 0 set;
  - a word access with address bits 1:0 nonzero.
  An aborted access writes nothing and returns zero read data.
- R5: An access whose full 32-bit address lies in [PROT_LO, PROT_HI) raises `cpu_abort` and writes nothing. The defaults are 0x400 and 0x440.
- R6: The RAM word is selected by address bits 9:2. Higher bits take part only in the window compare, so addresses that differ only there alias the same word.
- R7: The alternate master is granted at an edge where all of these hold: `alt_req` is high, `cpu_req_n` is high, `cpu_lock` is low, and no sequential reservation is pending. `alt_gnt` is then high for the next cycle. In that cycle `alt_rdata` shows the word at `alt_idx`, and if `alt_wr` is high, `alt_wdata` is written to that word at the end of the cycle.
- R8: When both masters request at the same edge, the processor gets the next cycle and `alt_gnt` stays low.
- R9: While `cpu_lock` is high at an edge, no grant is issued for the following cycle.
- R10: A request sampled with `cpu_seq` high reserves the cycle after its data phase for the processor. No grant is issued at the edge that ends that data phase.
- R11: After reset the RAM holds zeros and `cpu_rdata`, `cpu_abort` and `alt_gnt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_n | input | 1 | Processor request, active low, address phase |
| cpu_wr | input | 1 | High for write, low for read |
| cpu_size | input | 2 | Access size code |
| cpu_addr | input | 32 | Byte address |
| cpu_lock | input | 1 | Lock for the following access |
| cpu_seq | input | 1 | Sequential hint |
| cpu_wdata | input | 32 | Write data, data phase |
| cpu_rdata | output | 32 | Read data, data phase |
| cpu_abort | output | 1 | Access refused, data phase |
| alt_req | input | 1 | Alternate master request |
| alt_wr | input | 1 | Alternate master write enable |
| alt_idx | input | 8 | Alternate master word index |
| alt_wdata | input | 32 | Alternate master write data |
| alt_gnt | output | 1 | Alternate master owns this cycle |
| alt_rdata | output | 32 | Alternate master read data |

## Verification
A wrong captured request shows up one cycle after the address phase. It appears as a wrong `cpu_abort` level or wrong `cpu_rdata` in that same data phase. A wrongly enabled byte lane is invisible until a later read of that word, so the bench keeps a shadow memory and re-reads words across random sizes and lanes. A state-machine error surfaces as `alt_gnt` high in a cycle the processor owns, or one cycle late, and the grant is checked every cycle of the arbitration cases.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    parameter int unsigned LANE_BITS = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_CPU  = 2'd1,
        S_ALT  = 2'd2
    } port_state_e;

    typedef struct packed {
        logic                 wr;
        acc_size_e            sz;
        logic [LANE_BITS-1:0] lane;
        logic                 bad;
        logic                 seq;
    } req_cap_t;

endpackage

// File: rtl/dpm_req_stage.sv
module dpm_req_stage
    import dpm_pkg::*;
#(
    parameter int AW = 32,
    parameter int IDX_W = 8,
    parameter logic [AW-1:0] PROT_LO = 'h400,
    parameter logic [AW-1:0] PROT_HI = 'h440
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_n,
    input  logic             wr,
    input  logic [1:0]       size,
    input  logic [AW-1:0]    addr,
    input  logic             seq,
    output req_cap_t         cap_q,
    output logic [IDX_W-1:0] idx_q
);

    acc_size_e sz;
    logic      misal;
    logic      in_win;

    assign sz = acc_size_e'(size);

    always_comb begin
        unique case (sz)
            SZ_BYTE: misal = 1'b0;
            SZ_HALF: misal = addr[0];
            SZ_WORD: misal = |addr[1:0];
            default: misal = 1'b1;
        endcase
    end

    assign in_win = (addr >= PROT_LO) && (addr < PROT_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
            idx_q <= '0;
        end else if (!req_n) begin
            cap_q.wr   <= wr;
            cap_q.sz   <= sz;
            cap_q.lane <= addr[LANE_BITS-1:0];
            cap_q.bad  <= misal | in_win;
            cap_q.seq  <= seq;
            idx_q      <= addr[LANE_BITS +: IDX_W];
        end
    end

    p_reserved_aborts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && size == 2'b11) |=> cap_q.bad);

endmodule

// File: rtl/dpm_lane_steer.sv
module dpm_lane_steer
    import dpm_pkg::*;
#(
    parameter int DW = 32,
    localparam int NB = DW / 8
) (
    input  acc_size_e            sz,
    input  logic [LANE_BITS-1:0] lane,
    input  logic [DW-1:0]        word,
    output logic [NB-1:0]        be,
    output logic [DW-1:0]        rd
);

    logic [DW-1:0] sh_b;
    logic [DW-1:0] sh_h;

    for (genvar k = 0; k < NB; k++) begin : g_lane
        assign be[k] = (sz == SZ_WORD)
                    || (sz == SZ_HALF && (k / 2) == int'(lane >> 1))
                    || (sz == SZ_BYTE && k == int'(lane));
    end

    assign sh_b = word >> {lane, 3'b000};
    assign sh_h = word >> {lane[LANE_BITS-1:1], 4'b0000};

    always_comb begin
        unique case (sz)
            SZ_BYTE: rd = DW'(sh_b[7:0]);
            SZ_HALF: rd = DW'(sh_h[15:0]);
            SZ_WORD: rd = word;
            default: rd = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown(sz)) begin
            p_byte_single_lane_r3: assert (sz != SZ_BYTE || $countones(be) == 1);
        end
    end

endmodule

// File: rtl/dpm_word_ram.sv
module dpm_word_ram #(
    parameter int DW = 32,
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int NB = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [NB-1:0]    be,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            for (int k = 0; k < NB; k++) begin
                if (be[k]) begin
                    mem[idx][8*k +: 8] <= wdata[8*k +: 8];
                end
            end
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/dp_mem_slave.sv
module dp_mem_slave
    import dpm_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int DEPTH = 256,
    parameter logic [AW-1:0] PROT_LO = 'h400,
    parameter logic [AW-1:0] PROT_HI = 'h440,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int NB = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req_n,
    input  logic             cpu_wr,
    input  logic [1:0]       cpu_size,
    input  logic [AW-1:0]    cpu_addr,
    input  logic             cpu_lock,
    input  logic             cpu_seq,
    input  logic [DW-1:0]    cpu_wdata,
    output logic [DW-1:0]    cpu_rdata,
    output logic             cpu_abort,
    input  logic             alt_req,
    input  logic             alt_wr,
    input  logic [IDX_W-1:0] alt_idx,
    input  logic [DW-1:0]    alt_wdata,
    output logic             alt_gnt,
    output logic [DW-1:0]    alt_rdata
);

    port_state_e      state_q, state_d;
    req_cap_t         cap_q;
    logic [IDX_W-1:0] idx_q;
    logic [NB-1:0]    lane_be;
    logic [DW-1:0]    steered;
    logic [IDX_W-1:0] ram_idx;
    logic [NB-1:0]    ram_be;
    logic [DW-1:0]    ram_wdata;
    logic [DW-1:0]    ram_rdata;
    logic             cpu_phase;
    logic             alt_free;

    dpm_req_stage #(
        .AW(AW), .IDX_W(IDX_W), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
    ) u_req (
        .clk(clk), .rst_n(rst_n), .req_n(cpu_req_n), .wr(cpu_wr),
        .size(cpu_size), .addr(cpu_addr), .seq(cpu_seq),
        .cap_q(cap_q), .idx_q(idx_q)
    );

    dpm_lane_steer #(.DW(DW)) u_lane (
        .sz(cap_q.sz), .lane(cap_q.lane), .word(ram_rdata),
        .be(lane_be), .rd(steered)
    );

    dpm_word_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .rst_n(rst_n), .idx(ram_idx), .be(ram_be),
        .wdata(ram_wdata), .rdata(ram_rdata)
    );

    assign alt_free = alt_req && cpu_req_n && !cpu_lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE, S_ALT: begin
                if (!cpu_req_n)    state_d = S_CPU;
                else if (alt_free) state_d = S_ALT;
            end
            S_CPU: begin
                if (!cpu_req_n)                   state_d = S_CPU;
                else if (alt_free && !cap_q.seq)  state_d = S_ALT;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        cpu_phase = (state_q == S_CPU);
        alt_gnt   = (state_q == S_ALT);
        cpu_abort = cpu_phase && cap_q.bad;
        ram_idx   = alt_gnt ? alt_idx : idx_q;
        ram_be    = '0;
        ram_wdata = cpu_wdata;
        if (cpu_phase && cap_q.wr && !cap_q.bad) begin
            ram_be = lane_be;
        end else if (alt_gnt && alt_wr) begin
            ram_be    = '1;
            ram_wdata = alt_wdata;
        end
        cpu_rdata = (cpu_phase && !cap_q.wr && !cap_q.bad) ? steered : '0;
        alt_rdata = alt_gnt ? ram_rdata : '0;
    end

    p_abort_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_abort |-> $past(!cpu_req_n));

    p_abort_blocks_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_abort |-> (ram_be == '0));

    p_cpu_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req_n |=> !alt_gnt);

    p_lock_holds_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_lock |=> !alt_gnt);

    p_grant_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alt_gnt |-> $past(alt_req && cpu_req_n));

endmodule

// File: tb/tb_dp_mem_slave.sv
module tb_dp_mem_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_n = 1'b1;
    logic        cpu_wr = 1'b0;
    logic [1:0]  cpu_size = 2'b10;
    logic [31:0] cpu_addr = '0;
    logic        cpu_lock = 1'b0;
    logic        cpu_seq = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_abort;
    logic        alt_req = 1'b0;
    logic        alt_wr = 1'b0;
    logic [7:0]  alt_idx = '0;
    logic [31:0] alt_wdata = '0;
    logic        alt_gnt;
    logic [31:0] alt_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] mem_m [256];

    always #2.5 clk = ~clk;

    dp_mem_slave dut (
        .clk(clk), .rst_n(rst_n), .cpu_req_n(cpu_req_n), .cpu_wr(cpu_wr),
        .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_lock(cpu_lock),
        .cpu_seq(cpu_seq), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_abort(cpu_abort), .alt_req(alt_req), .alt_wr(alt_wr),
        .alt_idx(alt_idx), .alt_wdata(alt_wdata), .alt_gnt(alt_gnt),
        .alt_rdata(alt_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic bit f_bad(input logic [1:0] sz, input logic [31:0] a);
        return (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00)
            || (a >= 32'h400 && a < 32'h440);
    endfunction

    function automatic logic [31:0] f_rd(input logic [31:0] w, input logic [1:0] sz,
                                         input logic [1:0] ln);
        case (sz)
            2'b00:   return (w >> (8 * ln)) & 32'hff;
            2'b01:   return (w >> (16 * ln[1])) & 32'hffff;
            default: return w;
        endcase
    endfunction

    task automatic m_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd);
        for (int k = 0; k < 4; k++) begin
            bit en;
            en = (sz == 2'b10) || (sz == 2'b01 && (k / 2) == int'(a[1])) ||
                 (sz == 2'b00 && k == int'(a[1:0]));
            if (en) mem_m[a[9:2]][8*k +: 8] = wd[8*k +: 8];
        end
    endtask

    // Called just after a falling edge; returns just after the next falling edge.
    task automatic cpu_op(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd, input string tag);
        bit bad;
        cpu_req_n = 1'b0; cpu_wr = wr; cpu_size = sz; cpu_addr = a;
        @(posedge clk);
        @(negedge clk);
        cpu_req_n = 1'b1; cpu_wdata = wd;
        #1;
        bad = f_bad(sz, a);
        check({tag, " abort"}, 32'(cpu_abort), 32'(bad));
        if (!wr) check({tag, " rdata"}, cpu_rdata, bad ? 32'h0 : f_rd(mem_m[a[9:2]], sz, a[1:0]));
        else     check({tag, " rdata on write"}, cpu_rdata, 32'h0);
        if (wr && !bad) m_write(a, sz, wd);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) mem_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R11 rdata after reset", cpu_rdata, 32'h0);
        check("R11 abort after reset", 32'(cpu_abort), 32'h0);
        check("R11 gnt after reset", 32'(alt_gnt), 32'h0);
        cpu_op(1'b0, 2'b10, 32'h14, 32'h0, "R11 ram cleared");

        // R2 R3: word write then sub-word accesses
        cpu_op(1'b1, 2'b10, 32'h8, 32'h11223344, "R1 word write");
        cpu_op(1'b0, 2'b00, 32'h9, 32'h0, "R2 byte lane1 read");
        cpu_op(1'b0, 2'b01, 32'hA, 32'h0, "R2 half upper read");
        cpu_op(1'b1, 2'b00, 32'hB, 32'hAB000000, "R3 byte lane3 write");
        cpu_op(1'b1, 2'b01, 32'h8, 32'h0000CDEF, "R3 half lower write");
        cpu_op(1'b0, 2'b10, 32'h8, 32'h0, "R3 merged word");

        // R4 misaligned and reserved
        cpu_op(1'b1, 2'b01, 32'h9, 32'hFFFFFFFF, "R4 misaligned half");
        cpu_op(1'b1, 2'b10, 32'hA, 32'hFFFFFFFF, "R4 misaligned word");
        cpu_op(1'b1, 2'b11, 32'h8, 32'hFFFFFFFF, "R4 reserved size");
        cpu_op(1'b0, 2'b10, 32'h8, 32'h0, "R4 word unchanged");

        // R5 window and R6 aliasing
        cpu_op(1'b1, 2'b10, 32'h404, 32'hDEADBEEF, "R5 window write");
        cpu_op(1'b0, 2'b10, 32'h004, 32'h0, "R5 alias untouched");
        cpu_op(1'b1, 2'b10, 32'h1010, 32'h5A5A0F0F, "R6 high alias write");
        cpu_op(1'b0, 2'b10, 32'h0010, 32'h0, "R6 low alias read");

        // R1 back-to-back write then read
        cpu_req_n = 1'b0; cpu_wr = 1'b1; cpu_size = 2'b10; cpu_addr = 32'h30;
        @(posedge clk); @(negedge clk);
        cpu_wdata = 32'h0BADF00D; cpu_wr = 1'b0; cpu_addr = 32'h30;
        #1;
        check("R1 pipelined write abort", 32'(cpu_abort), 32'h0);
        mem_m[12] = 32'h0BADF00D;
        @(posedge clk); @(negedge clk);
        cpu_req_n = 1'b1;
        #1;
        check("R1 read after write", cpu_rdata, 32'h0BADF00D);

        // R8 priority
        cpu_req_n = 1'b0; cpu_wr = 1'b0; cpu_size = 2'b10; cpu_addr = 32'h0;
        alt_req = 1'b1; alt_wr = 1'b0; alt_idx = 8'd12;
        @(posedge clk); @(negedge clk);
        cpu_req_n = 1'b1;
        #1;
        check("R8 cpu wins tie", 32'(alt_gnt), 32'h0);
        @(posedge clk); @(negedge clk);
        #1;
        check("R7 grant after cpu", 32'(alt_gnt), 32'h1);
        check("R7 alt read", alt_rdata, 32'h0BADF00D);
        alt_req = 1'b0;

        // R9 lock
        @(posedge clk); @(negedge clk);
        cpu_lock = 1'b1; alt_req = 1'b1;
        @(posedge clk); @(negedge clk);
        #1;
        check("R9 locked no grant", 32'(alt_gnt), 32'h0);
        cpu_lock = 1'b0;
        @(posedge clk); @(negedge clk);
        #1;
        check("R9 grant after unlock", 32'(alt_gnt), 32'h1);
        alt_req = 1'b0;

        // R10 sequential reservation
        @(posedge clk); @(negedge clk);
        cpu_req_n = 1'b0; cpu_seq = 1'b1; cpu_wr = 1'b0; cpu_addr = 32'h0; alt_req = 1'b1;
        @(posedge clk); @(negedge clk);
        cpu_req_n = 1'b1; cpu_seq = 1'b0;
        #1;
        check("R8 seq phase no grant", 32'(alt_gnt), 32'h0);
        @(posedge clk); @(negedge clk);
        #1;
        check("R10 reserved cycle", 32'(alt_gnt), 32'h0);
        @(posedge clk); @(negedge clk);
        #1;
        check("R10 grant later", 32'(alt_gnt), 32'h1);
        alt_req = 1'b0;

        // R7 alternate write, then cpu read
        @(posedge clk); @(negedge clk);
        alt_req = 1'b1; alt_wr = 1'b1; alt_idx = 8'd20; alt_wdata = 32'hCAFEF00D;
        @(posedge clk); @(negedge clk);
        #1;
        check("R7 alt write grant", 32'(alt_gnt), 32'h1);
        alt_req = 1'b0;
        mem_m[20] = 32'hCAFEF00D;
        @(posedge clk); @(negedge clk);
        alt_wr = 1'b0;
        cpu_op(1'b0, 2'b10, 32'h50, 32'h0, "R7 alt write seen");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] base;
            logic [31:0] a;
            logic [1:0]  sz;
            bit          wr;
            string       tag;
            case ($urandom % 4)
                0: base = 32'h0;
                1: base = 32'h1000;
                2: base = 32'h400;
                default: base = 32'hFFF00000;
            endcase
            a  = base | ($urandom % 64);
            sz = 2'($urandom % 4);
            wr = 1'($urandom % 2);
            if (a >= 32'h400 && a < 32'h440) tag = "R5 random";
            else if (f_bad(sz, a))           tag = "R4 random";
            else if (wr)                     tag = "R3 random";
            else                             tag = "R2 random";
            cpu_op(wr, sz, a, $urandom, tag);
        end
        for (int w = 0; w < 16; w++) begin
            cpu_op(1'b0, 2'b10, 32'(w * 4), 32'h0, "R6 final sweep");
        end
        finish_run();
    end

endmodule